// File: doc/BRIEF.md
# IPv4 Fast-Path Header Processor

This block sits in a router's forwarding pipeline. It receives the fixed 20-byte part of an IPv4 header as one 160-bit word and decides whether that header can be handled by the hardware fast path. It sorts each header into one of a small, fixed set of exception classes. A header that raises no exception leaves with its time-to-live reduced by one and its header checksum patched incrementally. The patched checksum equals the value a full recomputation would give. A header that raises any exception is passed on untouched, marked for the slow path, and carries a reason code that tells software why.

The header is laid out with bit 159 as the most significant bit of the first byte on the wire. Both sides of the block use a valid/ready handshake. One output register stage sits between input and output. It is controlled by a two-state machine. `ST_IDLE` means the output register holds nothing. `ST_HOLD` means it holds a result for downstream. The transitions are:

- `ST_IDLE` to `ST_HOLD` when a header is accepted.
- `ST_HOLD` to `ST_HOLD` when a new header replaces a drained one, or when a stalled result is held.
- `ST_HOLD` to `ST_IDLE` when the result drains and no new header arrives.

Top module: `ipv4_fastpath`

## Requirements
- R1: While reset (rst_n low) is asserted, and immediately after it is released, out_valid is 0 and in_ready is 1.
- R2: A header with version (bits 159:156) equal to 4, IHL (bits 155:152) equal to 5, TTL (bits 95:88) of 2 or more, more-fragments flag (bit 109) clear, fragment offset (bits 108:96) zero and a destination (bits 31:0) outside 224.0.0.0/4 is output with out_fast=1 and out_reason=0. Its TTL is one lower and every bit outside TTL and checksum (bits 79:64) is unchanged.
- R3: On the fast path, the output checksum equals the one's-complement header checksum recomputed over the whole updated header.
- R4: A header whose version is not 4, or whose IHL is below 5, gets reason code 1.
- R5: A header arriving with TTL 0 or 1 gets reason code 2.
- R6: A header with IHL greater than 5 (options present) gets reason code 3.
- R7: A header with the more-fragments flag set or a nonzero fragment offset gets reason code 4. The don't-fragment flag (bit 110) on its own has no effect.
- R8: A header whose destination top nibble is 1110 gets reason code 5.
- R9: When several exceptions apply, the lowest reason code among them is reported (version, then TTL, options, fragment, multicast).
- R10: A header with a nonzero reason code is output with out_fast=0 and out_hdr equal to in_hdr bit for bit.
- R11: A header accepted at a clock edge (in_valid and in_ready high) appears on the outputs with out_valid=1 right after that same edge.
- R12: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold steady. With out_ready=1, one header is accepted and one is delivered on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input header present |
| in_ready | output | 1 | Block can take a header this cycle |
| in_hdr | input | 160 | Fixed IPv4 header, first byte in bits 159:152 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_hdr | output | 160 | Updated (fast) or untouched (slow) header |
| out_fast | output | 1 | 1 when the header took the fast path |
| out_reason | output | 3 | 0 for none, 1 bad version/IHL, 2 TTL, 3 options, 4 fragment, 5 multicast |

## Verification
The bench builds the block with its default multicast match parameters: a 4-bit prefix of value 1110. This makes the boundary destinations 223.x, 224.x, 239.x and 240.x the decisive cases for the multicast class. With these defaults, every exception class is reachable on its own and in combination, so the priority order can be exercised. Both edges of the TTL range (0, 1, 2 and 255) can be reached, as can the extreme fragment offsets. Stalls and back-to-back streaming exercise every transition of the output state machine.

// File: rtl/ipv4_fp_pkg.sv
package ipv4_fp_pkg;

    localparam int HDR_W    = 160;
    localparam int WORD_W   = 16;
    localparam int N_WORDS  = HDR_W / WORD_W;

    // field positions (network byte order, first byte at the top)
    localparam int VER_LSB  = 156;
    localparam int IHL_LSB  = 152;
    localparam int MF_BIT   = 109;
    localparam int OFF_LSB  = 96;
    localparam int OFF_W    = 13;
    localparam int TTL_LSB  = 88;
    localparam int TTL_W    = 8;
    localparam int CSUM_LSB = 64;
    localparam int DST_LSB  = 0;
    localparam int DST_W    = 32;

    localparam int RSN_W    = 3;

    typedef logic [HDR_W-1:0] hdr_t;

    typedef enum logic [RSN_W-1:0] {
        RSN_NONE    = 3'd0,
        RSN_VERSION = 3'd1,
        RSN_TTL     = 3'd2,
        RSN_OPTIONS = 3'd3,
        RSN_FRAG    = 3'd4,
        RSN_MCAST   = 3'd5
    } reason_e;

    localparam int N_RSN = 6;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ostate_e;

endpackage

// File: rtl/ipv4_fp_classify.sv
module ipv4_fp_classify
    import ipv4_fp_pkg::*;
#(
    parameter int                 MCAST_W   = 4,
    parameter logic [MCAST_W-1:0] MCAST_VAL = 'hE
) (
    input  logic [3:0]         ver,
    input  logic [3:0]         ihl,
    input  logic [TTL_W-1:0]   ttl,
    input  logic               more_frag,
    input  logic [OFF_W-1:0]   frag_off,
    input  logic [MCAST_W-1:0] dst_hi,
    output reason_e            reason
);

    logic [N_RSN-1:0] hit;

    always_comb begin
        hit              = '0;
        hit[RSN_VERSION] = (ver != 4'd4) || (ihl < 4'd5);
        hit[RSN_TTL]     = (ttl < 8'd2);
        hit[RSN_OPTIONS] = (ihl > 4'd5);
        hit[RSN_FRAG]    = more_frag || (frag_off != '0);
        hit[RSN_MCAST]   = (dst_hi == MCAST_VAL);
    end

    // lowest-numbered exception wins
    always_comb begin
        reason = RSN_NONE;
        for (int k = N_RSN - 1; k >= 1; k--) begin
            if (hit[k]) reason = reason_e'(RSN_W'(k));
        end
    end

endmodule

// File: rtl/ipv4_fp_patch.sv
module ipv4_fp_patch
    import ipv4_fp_pkg::*;
(
    input  hdr_t hdr_in,
    output hdr_t hdr_out
);

    logic [TTL_W-1:0]  ttl_new;
    logic [WORD_W-1:0] csum_old;
    logic [WORD_W:0]   raw_sum;
    logic [WORD_W-1:0] folded;

    // TTL sits in the upper byte of its 16-bit word, so the word drops by
    // 0x0100; the complement of the change is 0xFEFF in one's complement.
    localparam logic [WORD_W-1:0] DELTA_C = 16'hFEFF;

    always_comb begin
        ttl_new  = hdr_in[TTL_LSB +: TTL_W] - 8'd1;
        csum_old = hdr_in[CSUM_LSB +: WORD_W];
        raw_sum  = {1'b0, ~csum_old} + {1'b0, DELTA_C};
        folded   = raw_sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw_sum[WORD_W]};

        hdr_out                        = hdr_in;
        hdr_out[TTL_LSB +: TTL_W]      = ttl_new;
        hdr_out[CSUM_LSB +: WORD_W]    = ~folded;
    end

endmodule

// File: rtl/ipv4_fp_outreg.sv
module ipv4_fp_outreg
    import ipv4_fp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    in_valid,
    output logic    in_ready,
    input  hdr_t    d_hdr,
    input  logic    d_fast,
    input  reason_e d_reason,
    output logic    out_valid,
    input  logic    out_ready,
    output hdr_t    q_hdr,
    output logic    q_fast,
    output reason_e q_reason
);

    ostate_e state, state_nxt;
    logic    load;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (in_valid)                state_nxt = ST_HOLD;
            ST_HOLD: if (out_ready && !in_valid)  state_nxt = ST_IDLE;
        endcase
    end

    assign in_ready  = (state == ST_IDLE) || out_ready;
    assign load      = in_valid && in_ready;
    assign out_valid = (state == ST_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_hdr    <= '0;
            q_fast   <= 1'b0;
            q_reason <= RSN_NONE;
        end else if (load) begin
            q_hdr    <= d_hdr;
            q_fast   <= d_fast;
            q_reason <= d_reason;
        end
    end

endmodule

// File: rtl/ipv4_fastpath.sv
module ipv4_fastpath
    import ipv4_fp_pkg::*;
#(
    parameter int                 MCAST_W   = 4,
    parameter logic [MCAST_W-1:0] MCAST_VAL = 'hE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [159:0] in_hdr,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [159:0] out_hdr,
    output logic         out_fast,
    output logic [2:0]   out_reason
);

    reason_e rsn, q_rsn;
    hdr_t    patched, chosen;
    logic    fast;

    ipv4_fp_classify #(
        .MCAST_W   (MCAST_W),
        .MCAST_VAL (MCAST_VAL)
    ) u_classify (
        .ver       (in_hdr[VER_LSB +: 4]),
        .ihl       (in_hdr[IHL_LSB +: 4]),
        .ttl       (in_hdr[TTL_LSB +: TTL_W]),
        .more_frag (in_hdr[MF_BIT]),
        .frag_off  (in_hdr[OFF_LSB +: OFF_W]),
        .dst_hi    (in_hdr[DST_LSB + DST_W - MCAST_W +: MCAST_W]),
        .reason    (rsn)
    );

    ipv4_fp_patch u_patch (
        .hdr_in  (in_hdr),
        .hdr_out (patched)
    );

    assign fast   = (rsn == RSN_NONE);
    assign chosen = fast ? patched : in_hdr;

    ipv4_fp_outreg u_outreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .d_hdr     (chosen),
        .d_fast    (fast),
        .d_reason  (rsn),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .q_hdr     (out_hdr),
        .q_fast    (out_fast),
        .q_reason  (q_rsn)
    );

    assign out_reason = q_rsn;

endmodule

// File: rtl/ipv4_fp_checker.sv
module ipv4_fp_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         in_ready,
    input logic [159:0] in_hdr,
    input logic         out_valid,
    input logic         out_ready,
    input logic [159:0] out_hdr,
    input logic         out_fast,
    input logic [2:0]   out_reason
);

    logic [159:0] cap;

    function automatic logic [15:0] fold_sum(input logic [159:0] h);
        logic [31:0] acc;
        acc = '0;
        for (int i = 0; i < 10; i++) acc = acc + {16'd0, h[i*16 +: 16]};
        acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
        acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
        return acc[15:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cap <= '0;
        else if (in_valid && in_ready) cap <= in_hdr;
    end

    wire cap_ok = (fold_sum(cap) == 16'hFFFF);

    a_r11_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    a_r12_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_hdr)
                                 && $stable(out_fast) && $stable(out_reason));

    a_r12_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    a_r10_slow_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_fast |-> out_hdr == cap);

    a_r2_ttl_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fast |-> (out_hdr[95:88] == cap[95:88] - 8'd1)
            && (out_hdr[159:96] == cap[159:96]) && (out_hdr[87:80] == cap[87:80])
            && (out_hdr[63:0] == cap[63:0]));

    a_r3_checksum_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_fast && cap_ok |-> fold_sum(out_hdr) == 16'hFFFF);

    a_r2_flag_matches_code: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_fast == (out_reason == 3'd0));

    a_r5_expiring_slow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (cap[95:89] == 7'd0) |-> !out_fast);

    a_r8_multicast_slow: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (cap[31:28] == 4'hE) |-> !out_fast);

endmodule

bind ipv4_fastpath ipv4_fp_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_hdr     (in_hdr),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_hdr    (out_hdr),
    .out_fast   (out_fast),
    .out_reason (out_reason)
);

// File: tb/test_ipv4_fastpath.sv
module test_ipv4_fastpath;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [159:0] in_hdr = '0;
    logic         out_valid;
    logic         out_ready = 1'b1;
    logic [159:0] out_hdr;
    logic         out_fast;
    logic [2:0]   out_reason;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2 clk = ~clk;

    ipv4_fastpath i_ipv4_fastpath (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .out_valid(out_valid), .out_ready(out_ready),
        .out_hdr(out_hdr), .out_fast(out_fast), .out_reason(out_reason)
    );

    // ver, ihl, ttl, df, mf, offset, dst first byte, expected reason
    localparam int NV = 20;
    localparam logic [41:0] VECS [NV] = '{
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'd0,    8'd10,  3'd0},
        {4'd4, 4'd5,  8'd2,   1'b0, 1'b0, 13'd0,    8'd192, 3'd0},
        {4'd4, 4'd5,  8'd255, 1'b0, 1'b0, 13'd0,    8'd223, 3'd0},
        {4'd6, 4'd5,  8'd64,  1'b0, 1'b0, 13'd0,    8'd10,  3'd1},
        {4'd4, 4'd4,  8'd64,  1'b0, 1'b0, 13'd0,    8'd10,  3'd1},
        {4'd4, 4'd5,  8'd1,   1'b0, 1'b0, 13'd0,    8'd10,  3'd2},
        {4'd4, 4'd5,  8'd0,   1'b0, 1'b0, 13'd0,    8'd10,  3'd2},
        {4'd4, 4'd6,  8'd64,  1'b0, 1'b0, 13'd0,    8'd10,  3'd3},
        {4'd4, 4'd15, 8'd64,  1'b0, 1'b0, 13'd0,    8'd10,  3'd3},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b1, 13'd0,    8'd10,  3'd4},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'd1,    8'd10,  3'd4},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'h1FFF, 8'd10,  3'd4},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'd0,    8'd224, 3'd5},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'd0,    8'd239, 3'd5},
        {4'd4, 4'd5,  8'd64,  1'b0, 1'b0, 13'd0,    8'd240, 3'd0},
        {4'd5, 4'd7,  8'd0,   1'b0, 1'b1, 13'd5,    8'd230, 3'd1},
        {4'd4, 4'd7,  8'd1,   1'b0, 1'b1, 13'd0,    8'd230, 3'd2},
        {4'd4, 4'd6,  8'd9,   1'b0, 1'b0, 13'd3,    8'd225, 3'd3},
        {4'd4, 4'd5,  8'd9,   1'b0, 1'b1, 13'd0,    8'd225, 3'd4},
        {4'd4, 4'd5,  8'd33,  1'b1, 1'b0, 13'd0,    8'd10,  3'd0}
    };

    function automatic logic [15:0] ones_sum(input logic [159:0] h);
        logic [31:0] acc = '0;
        for (int i = 0; i < 10; i++) acc += {16'd0, h[i*16 +: 16]};
        acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
        acc = {16'd0, acc[15:0]} + {16'd0, acc[31:16]};
        return acc[15:0];
    endfunction

    function automatic logic [159:0] build(input logic [41:0] v, input logic [15:0] id);
        logic [159:0] h = '0;
        h[159:156] = v[41:38];
        h[155:152] = v[37:34];
        h[143:128] = 16'd84;
        h[127:112] = id;
        h[110]     = v[25];
        h[109]     = v[24];
        h[108:96]  = v[23:11];
        h[95:88]   = v[33:26];
        h[87:80]   = 8'd17;
        h[63:32]   = 32'hC0A80A01;
        h[31:0]    = {v[10:3], 24'h123456};
        h[79:64]   = ~ones_sum(h);
        return h;
    endfunction

    function automatic logic [159:0] expect_hdr(input logic [159:0] h, input logic [2:0] rsn);
        logic [159:0] t = h;
        if (rsn == 3'd0) begin
            t[95:88] = h[95:88] - 8'd1;
            t[79:64] = 16'd0;
            t[79:64] = ~ones_sum(t);
        end
        return t;
    endfunction

    function automatic string tag_of(input logic [2:0] rsn, input int idx);
        if (idx >= 15 && idx <= 18) return "R9";
        case (rsn)
            3'd1:    return "R4";
            3'd2:    return "R5";
            3'd3:    return "R6";
            3'd4:    return "R7";
            3'd5:    return "R8";
            default: return "R2";
        endcase
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_out(input logic [159:0] h, input logic [2:0] rsn, input string tag);
        logic [159:0] e = expect_hdr(h, rsn);
        check(out_valid == 1'b1, "R11", {159'd0, out_valid}, 160'd1);
        check(out_reason == rsn, tag, {157'd0, out_reason}, {157'd0, rsn});
        check(out_fast == (rsn == 3'd0), tag, {159'd0, out_fast}, {159'd0, rsn == 3'd0});
        if (rsn == 3'd0) begin
            check(out_hdr[79:64] == e[79:64], "R3", out_hdr, e);
            check(out_hdr == e, "R2", out_hdr, e);
        end else begin
            check(out_hdr == h, "R10", out_hdr, h);
        end
    endtask

    initial begin
        logic [159:0] ha, hb;
        #3;
        check(out_valid == 1'b0, "R1", {159'd0, out_valid}, 160'd0);
        check(in_ready == 1'b1, "R1", {159'd0, in_ready}, 160'd1);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", {159'd0, out_valid}, 160'd0);
        check(in_ready == 1'b1, "R1", {159'd0, in_ready}, 160'd1);

        // table walk, one header per cycle
        for (int i = 0; i < NV; i++) begin
            ha = build(VECS[i], 16'h1C46 + 16'(i * 16'h1111));
            in_hdr   = ha;
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            check_out(ha, VECS[i][2:0], tag_of(VECS[i][2:0], i));
        end

        // R11: nothing offered, result drains and out_valid falls
        @(negedge clk);
        check(out_valid == 1'b0, "R11", {159'd0, out_valid}, 160'd0);

        // R12: back-to-back streaming
        ha = build(VECS[0], 16'hAAAA);
        hb = build(VECS[12], 16'h5555);
        in_hdr = ha; in_valid = 1'b1;
        @(negedge clk);
        check_out(ha, 3'd0, "R12");
        in_hdr = hb;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(hb, 3'd5, "R12");
        @(negedge clk);

        // R12: backpressure
        out_ready = 1'b0;
        in_hdr = ha; in_valid = 1'b1;
        @(negedge clk);
        check(out_hdr == expect_hdr(ha, 3'd0), "R12", out_hdr, expect_hdr(ha, 3'd0));
        check(in_ready == 1'b0, "R12", {159'd0, in_ready}, 160'd0);
        in_hdr = hb;
        @(negedge clk);
        check(out_valid == 1'b1, "R12", {159'd0, out_valid}, 160'd1);
        check(out_hdr == expect_hdr(ha, 3'd0), "R12", out_hdr, expect_hdr(ha, 3'd0));
        check(out_fast == 1'b1, "R12", {159'd0, out_fast}, 160'd1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_out(hb, 3'd5, "R12");
        @(negedge clk);
        check(out_valid == 1'b0, "R12", {159'd0, out_valid}, 160'd0);

        // R1: reset while a result is held
        out_ready = 1'b0;
        in_hdr = ha; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1", {159'd0, out_valid}, 160'd0);
        check(in_ready == 1'b1, "R1", {159'd0, in_ready}, 160'd1);
        @(negedge clk); rst_n = 1'b1; out_ready = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", {159'd0, out_valid}, 160'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule